// File: doc/BRIEF.md
# 4B5B Receive Symbol Decoder with Stream Framing

This block takes aligned 5-bit code-groups from a 100 Mb/s receive path, one per symbol strobe, and turns them into 4-bit nibbles with a data-valid flag, an error flag and a carrier-sense indication of the kind a MAC-facing nibble interface expects. It follows the stream structure on the line. A two-symbol start delimiter opens a frame. Data code-groups inside the frame are decoded. A two-symbol end delimiter closes it.

Inside a frame, any code-group that is not data is reported as a coding error: an invalid code-group, or a stray control symbol. The nibble shown with the error is fixed by a configuration input, so a MAC can tell a line error from received data. Frames that end early, or that start with a broken delimiter, are closed with a one-strobe error report. Every output is registered and changes only on a strobe edge, so the block adds exactly one symbol of latency.

Top module: `rx4b5b_deframer`

## Requirements
- R1: While reset is asserted, and after it until the first strobe, nibble is 0h and the valid, error and carrier-sense outputs are all 0.
- R2: The outputs change only on a clock edge where the strobe is high, and they reflect the symbol presented with that strobe. Between strobes they hold their values, whatever the symbol input does.
- R3: Inside a frame, the data code-groups 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100 and 11101 decode to nibbles 0h through Fh in that order, with valid 1, error 0 and carrier sense 1.
- R4: Outside a frame, 11000 followed by 10001 opens a frame. Both strobes output nibble 5h with valid 0 and error 0. Carrier sense is 1 from the first of the two strobes onward.
- R5: Outside a frame, every symbol except 11000 gives nibble 0h, valid 0, error 0 and carrier sense 0.
- R6: Inside a frame, a code-group that is neither data nor control gives error 1, valid 1 and carrier sense 1. Such code-groups are 00000, 00001, 00010, 00011, 00100, 00101, 00110, 01000, 01100, 10000 and 11001. The nibble is 5h when the configuration bit presented with that strobe is 0, and 6h when it is 1.
- R7: Inside a frame, the control symbols 11000, 10001 and 00111 are violations and are reported exactly as in R6. The frame stays open.
- R8: Inside a frame, 01101 followed by 00111 closes the frame. Both strobes output nibble 0h, valid 0 and error 0. Carrier sense is 1 on the first strobe and 0 on the second.
- R9: The idle symbol 11111 received inside a frame, or directly after 01101, closes the frame early. That strobe outputs error 1, valid 0, carrier sense 0 and the selected error nibble.
- R10: A 11000 that is not followed by 10001 is a false start. The following strobe outputs error 1, valid 0, carrier sense 0 and the selected error nibble, and decoding returns to outside-frame.
- R11: A 01101 followed by anything other than 00111 or 11111 makes that second strobe a violation, reported as in R6. The frame stays open and the next symbol is decoded as data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_i | input | 5 | Aligned received code-group |
| sym_stb_i | input | 1 | Marks the cycle in which sym_i is a new code-group |
| err6_sel_i | input | 1 | Error nibble select: 0 gives 5h, 1 gives 6h |
| nib_o | output | 4 | Decoded or substituted nibble |
| dv_o | output | 1 | Data valid: the frame is open and this strobe carried a data slot |
| er_o | output | 1 | Coding or framing error on this strobe |
| crs_o | output | 1 | Carrier sense: a frame is being received |

## Verification
The framing state cannot be seen at the ports, so a wrong state shows up as a wrong flag on the very next strobe. A machine stuck outside the frame drops valid and carrier sense on the first data symbol. A machine stuck inside the frame raises valid or error on symbols that should be ignored. A lost delimiter half shows up as a missing or extra error pulse one strobe after the delimiter. The bench therefore walks each delimiter pair in its good and broken forms. It decodes every code-group both inside and outside a frame, and compares all four outputs on every clock. With the outputs compared on every clock, any such fault appears within one strobe.

// File: rtl/rx4b5b_pkg.sv
package rx4b5b_pkg;

  localparam int SYM_W = 5;
  localparam int NIB_W = 4;

  typedef enum logic [2:0] {
    SC_DATA,
    SC_SSD1,
    SC_SSD2,
    SC_ESD1,
    SC_ESD2,
    SC_IDLE,
    SC_BAD
  } sym_class_e;

  typedef enum logic [1:0] {
    FS_OUT,
    FS_SSD,
    FS_IN,
    FS_ESD
  } frame_st_e;

  function automatic sym_class_e classify(input logic [SYM_W-1:0] s);
    case (s)
      5'b11000: classify = SC_SSD1;
      5'b10001: classify = SC_SSD2;
      5'b01101: classify = SC_ESD1;
      5'b00111: classify = SC_ESD2;
      5'b11111: classify = SC_IDLE;
      5'b11110, 5'b01001, 5'b10100, 5'b10101,
      5'b01010, 5'b01011, 5'b01110, 5'b01111,
      5'b10010, 5'b10011, 5'b10110, 5'b10111,
      5'b11010, 5'b11011, 5'b11100, 5'b11101: classify = SC_DATA;
      default: classify = SC_BAD;
    endcase
  endfunction

  function automatic logic [NIB_W-1:0] data_nibble(input logic [SYM_W-1:0] s);
    case (s)
      5'b11110: data_nibble = 4'h0;
      5'b01001: data_nibble = 4'h1;
      5'b10100: data_nibble = 4'h2;
      5'b10101: data_nibble = 4'h3;
      5'b01010: data_nibble = 4'h4;
      5'b01011: data_nibble = 4'h5;
      5'b01110: data_nibble = 4'h6;
      5'b01111: data_nibble = 4'h7;
      5'b10010: data_nibble = 4'h8;
      5'b10011: data_nibble = 4'h9;
      5'b10110: data_nibble = 4'hA;
      5'b10111: data_nibble = 4'hB;
      5'b11010: data_nibble = 4'hC;
      5'b11011: data_nibble = 4'hD;
      5'b11100: data_nibble = 4'hE;
      5'b11101: data_nibble = 4'hF;
      default:  data_nibble = 4'h0;
    endcase
  endfunction

  function automatic logic [NIB_W-1:0] err_nibble(input logic sel6);
    err_nibble = sel6 ? 4'h6 : 4'h5;
  endfunction

endpackage

// File: rtl/rx4b5b_classify.sv
module rx4b5b_classify
  import rx4b5b_pkg::*;
(
  input  logic [SYM_W-1:0] sym_i,
  output sym_class_e       cls_o,
  output logic [NIB_W-1:0] dnib_o
);

  always_comb begin
    cls_o  = classify(sym_i);
    dnib_o = data_nibble(sym_i);
  end

endmodule

// File: rtl/rx4b5b_frame_ctl.sv
module rx4b5b_frame_ctl
  import rx4b5b_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb_i,
  input  sym_class_e       cls_i,
  input  logic [NIB_W-1:0] dnib_i,
  input  logic             err6_sel_i,
  output logic [NIB_W-1:0] nib_o,
  output logic             dv_o,
  output logic             er_o,
  output logic             crs_o
);

  frame_st_e        st_q, st_n;
  logic [NIB_W-1:0] nib_n;
  logic             dv_n, er_n, crs_n;
  logic [NIB_W-1:0] enib;

  // named events for the assertions
  logic ev_open, ev_close, ev_early_end, ev_false_start;

  assign enib = err_nibble(err6_sel_i);

  always_comb begin
    st_n  = st_q;
    nib_n = '0;
    dv_n  = 1'b0;
    er_n  = 1'b0;
    crs_n = 1'b0;
    case (st_q)
      FS_OUT: begin
        if (cls_i == SC_SSD1) begin
          st_n  = FS_SSD;
          crs_n = 1'b1;
          nib_n = 4'h5;
        end
      end
      FS_SSD: begin
        if (cls_i == SC_SSD2) begin
          st_n  = FS_IN;
          crs_n = 1'b1;
          nib_n = 4'h5;
        end else begin
          st_n  = FS_OUT;
          er_n  = 1'b1;
          nib_n = enib;
        end
      end
      FS_IN: begin
        case (cls_i)
          SC_DATA: begin
            dv_n  = 1'b1;
            crs_n = 1'b1;
            nib_n = dnib_i;
          end
          SC_ESD1: begin
            st_n  = FS_ESD;
            crs_n = 1'b1;
          end
          SC_IDLE: begin
            st_n  = FS_OUT;
            er_n  = 1'b1;
            nib_n = enib;
          end
          default: begin
            dv_n  = 1'b1;
            er_n  = 1'b1;
            crs_n = 1'b1;
            nib_n = enib;
          end
        endcase
      end
      FS_ESD: begin
        if (cls_i == SC_ESD2) begin
          st_n = FS_OUT;
        end else if (cls_i == SC_IDLE) begin
          st_n  = FS_OUT;
          er_n  = 1'b1;
          nib_n = enib;
        end else begin
          st_n  = FS_IN;
          dv_n  = 1'b1;
          er_n  = 1'b1;
          crs_n = 1'b1;
          nib_n = enib;
        end
      end
      default: st_n = FS_OUT;
    endcase
  end

  assign ev_open        = stb_i && (st_q == FS_SSD) && (cls_i == SC_SSD2);
  assign ev_close       = stb_i && (st_q == FS_ESD) && (cls_i == SC_ESD2);
  assign ev_early_end   = stb_i && (st_q == FS_IN || st_q == FS_ESD) && (cls_i == SC_IDLE);
  assign ev_false_start = stb_i && (st_q == FS_SSD) && (cls_i != SC_SSD2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= FS_OUT;
      nib_o <= '0;
      dv_o  <= 1'b0;
      er_o  <= 1'b0;
      crs_o <= 1'b0;
    end else if (stb_i) begin
      st_q  <= st_n;
      nib_o <= nib_n;
      dv_o  <= dv_n;
      er_o  <= er_n;
      crs_o <= crs_n;
    end
  end

  // R2: nothing moves without a strobe
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_i |=> $stable({nib_o, dv_o, er_o, crs_o}));

  // R3: valid data only ever appears with carrier sense
  p_dv_crs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dv_o |-> crs_o);

  // R6: an error always carries one of the two error nibbles
  p_er_nib_r6: assert property (@(posedge clk) disable iff (!rst_n)
    er_o |-> (nib_o == 4'h5 || nib_o == 4'h6));

  // R4: carrier sense rises only on a first start delimiter
  p_crs_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crs_o) |-> $past(stb_i && cls_i == SC_SSD1));

  // R8: a clean close leaves no flag raised
  p_close_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_close |=> (!crs_o && !dv_o && !er_o));

  // R9: an early end drops carrier with an error
  p_early_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_early_end |=> (!crs_o && er_o && !dv_o));

  // R10: a broken start reports an error outside the frame
  p_false_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_false_start |=> (!crs_o && er_o));

  // R4: the second start delimiter keeps carrier, no data yet
  p_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_open |=> (crs_o && !dv_o && nib_o == 4'h5));

endmodule

// File: rtl/rx4b5b_deframer.sv
module rx4b5b_deframer
  import rx4b5b_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SYM_W-1:0] sym_i,
  input  logic             sym_stb_i,
  input  logic             err6_sel_i,
  output logic [NIB_W-1:0] nib_o,
  output logic             dv_o,
  output logic             er_o,
  output logic             crs_o
);

  sym_class_e       cls;
  logic [NIB_W-1:0] dnib;

  rx4b5b_classify u_cls (
    .sym_i  (sym_i),
    .cls_o  (cls),
    .dnib_o (dnib)
  );

  rx4b5b_frame_ctl u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .stb_i      (sym_stb_i),
    .cls_i      (cls),
    .dnib_i     (dnib),
    .err6_sel_i (err6_sel_i),
    .nib_o      (nib_o),
    .dv_o       (dv_o),
    .er_o       (er_o),
    .crs_o      (crs_o)
  );

endmodule

// File: tb/rx4b5b_deframer_bench.sv
module rx4b5b_deframer_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] sym = 5'b11111;
  logic       stb = 1'b0;
  logic       sel = 1'b0;
  logic [3:0] nib;
  logic       dv, er, crs;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  // reference model state
  int       mst = 0;          // 0 outside, 1 after J, 2 in frame, 3 after T
  bit [3:0] e_nib = 4'h0;
  bit       e_dv = 0, e_er = 0, e_crs = 0;
  bit [4:0] codes [16];

  localparam bit [4:0] CJ = 5'b11000, CK = 5'b10001, CT = 5'b01101,
                       CR = 5'b00111, CI = 5'b11111;

  always #10 clk = ~clk;

  rx4b5b_deframer u_rx4b5b_deframer (
    .clk(clk), .rst_n(rst_n), .sym_i(sym), .sym_stb_i(stb),
    .err6_sel_i(sel), .nib_o(nib), .dv_o(dv), .er_o(er), .crs_o(crs)
  );

  function automatic int data_index(input bit [4:0] s);
    for (int i = 0; i < 16; i++) if (codes[i] == s) return i;
    return -1;
  endfunction

  function automatic void set_exp(input bit [3:0] n, input bit v, input bit e, input bit c);
    e_nib = n; e_dv = v; e_er = e; e_crs = c;
  endfunction

  function automatic void model(input bit [4:0] s, input bit sl);
    int di;
    bit [3:0] en;
    di = data_index(s);
    en = sl ? 4'd6 : 4'd5;
    case (mst)
      0: if (s == CJ) begin mst = 1; set_exp(4'd5, 0, 0, 1); end
         else set_exp(4'd0, 0, 0, 0);
      1: if (s == CK) begin mst = 2; set_exp(4'd5, 0, 0, 1); end
         else begin mst = 0; set_exp(en, 0, 1, 0); end
      2: if (di >= 0) set_exp(di[3:0], 1, 0, 1);
         else if (s == CT) begin mst = 3; set_exp(4'd0, 0, 0, 1); end
         else if (s == CI) begin mst = 0; set_exp(en, 0, 1, 0); end
         else set_exp(en, 1, 1, 1);
      default:
         if (s == CR) begin mst = 0; set_exp(4'd0, 0, 0, 0); end
         else if (s == CI) begin mst = 0; set_exp(en, 0, 1, 0); end
         else begin mst = 2; set_exp(en, 1, 1, 1); end
    endcase
  endfunction

  task automatic check(input string tag);
    tests++;
    if (nib !== e_nib || dv !== e_dv || er !== e_er || crs !== e_crs) begin
      fails++;
      $display("FAIL %s: got nib=%h dv=%b er=%b crs=%b expected nib=%h dv=%b er=%b crs=%b",
               tag, nib, dv, er, crs, e_nib, e_dv, e_er, e_crs);
    end
  endtask

  // present one symbol with a strobe, compare one cycle later
  task automatic send(input bit [4:0] s, input bit sl, input string tag);
    @(negedge clk);
    sym = s; sel = sl; stb = 1'b1;
    model(s, sl);
    @(negedge clk);
    stb = 1'b0;
    check(tag);
  endtask

  // cycles without strobe, symbol wiggling: outputs must hold (R2)
  task automatic gap(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sym = 5'(i * 7 + 3); sel = ~sel; stb = 1'b0;
      check("R2 hold");
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    codes = '{5'b11110, 5'b01001, 5'b10100, 5'b10101, 5'b01010, 5'b01011,
              5'b01110, 5'b01111, 5'b10010, 5'b10011, 5'b10110, 5'b10111,
              5'b11010, 5'b11011, 5'b11100, 5'b11101};
    repeat (3) @(negedge clk);
    check("R1 in reset");
    rst_n = 1'b1;
    gap(3);
    check("R1 after reset");

    // R5: outside frame everything but J is ignored
    send(CI, 0, "R5 idle");
    send(codes[3], 0, "R5 data");
    send(5'b00000, 1, "R5 invalid");
    send(CT, 0, "R5 T");
    send(CR, 0, "R5 R");
    send(CK, 0, "R5 K");

    // R4 open, R3 all data, R8 close
    send(CJ, 0, "R4 J");
    send(CK, 0, "R4 K");
    for (int i = 0; i < 16; i++) send(codes[i], 0, "R3 data");
    gap(2);
    send(codes[10], 0, "R2 after gap");
    send(CT, 0, "R8 T");
    send(CR, 0, "R8 R");
    send(CI, 0, "R8 idle after");

    // R6 invalid in frame both selections, R7 controls, R11 broken end
    send(CJ, 0, "R4 J");
    send(CK, 1, "R4 K");
    begin
      bit [4:0] bad [11] = '{5'b00000, 5'b00001, 5'b00010, 5'b00011, 5'b00100,
                             5'b00101, 5'b00110, 5'b01000, 5'b01100, 5'b10000, 5'b11001};
      for (int i = 0; i < 11; i++) send(bad[i], i[0], "R6 invalid");
    end
    send(CJ, 0, "R7 J in frame");
    send(CK, 1, "R7 K in frame");
    send(CR, 0, "R7 R in frame");
    send(codes[5], 0, "R7 frame kept");
    send(CT, 1, "R11 T");
    send(codes[2], 1, "R11 T then data");
    send(codes[7], 0, "R11 frame kept");
    send(CT, 0, "R11 T");
    send(CT, 0, "R11 T then T");
    send(CT, 0, "R8 T");
    send(CR, 0, "R8 R");

    // R9 premature idle, in frame and after T
    send(CJ, 0, "R4 J");
    send(CK, 0, "R4 K");
    send(codes[1], 0, "R3 data");
    send(CI, 1, "R9 idle in frame");
    send(codes[1], 0, "R9 now outside");
    send(CJ, 0, "R4 J");
    send(CK, 0, "R4 K");
    send(CT, 0, "R8 T");
    send(CI, 0, "R9 idle after T");

    // R10 false starts
    send(CJ, 0, "R4 J");
    send(codes[4], 1, "R10 J then data");
    send(codes[4], 0, "R10 now outside");
    send(CJ, 0, "R4 J");
    send(CI, 0, "R10 J then idle");
    send(CJ, 0, "R4 J");
    send(CJ, 1, "R10 J then J");
    send(CK, 0, "R10 K outside");
    gap(2);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule